// File: doc/BRIEF.md
# Transmit Interrupt Delay Timer

This block merges transmit-completion interrupts so that software is not interrupted once per descriptor. It observes descriptor write-back events. Each event is a one-cycle strobe that carries two flags: "report status" and "delay the interrupt". An event that has both flags set (re)starts a countdown from a software-programmed delay value. The countdown steps down once per pulse on a tick input, so the block needs no knowledge of clock frequencies. When the countdown expires, the block records a sticky interrupt cause.

An event that requests status but does not request the delay records the cause at once and cancels any countdown in progress. The delay flag has no effect on a descriptor that does not request status. The status write-back strobe for a descriptor is never held back by the timer. The cause bit stays set until software writes one to clear it. An enable input gates the cause onto the interrupt request line.

Top module: `tx_irq_delay_timer`

## Requirements
- R1: An event with `wb_valid_i`, `wb_rpt_i` and `wb_dly_i` all high loads the countdown from `dly_val_i` and arms it. A `tick_i` in that same cycle does not step the countdown.
- R2: A delay-flagged event that arrives while a countdown is running reloads the countdown from the current `dly_val_i` and restarts it.
- R3: An armed countdown that was loaded with value N expires on the (N+1)-th `tick_i` pulse after the load cycle. With N = 0 it expires on the first such tick. Expiry disarms the countdown.
- R4: An expiry sets `cause_o`, and `cause_o` reads high from the clock edge that follows the expiring tick.
- R5: An event with `wb_rpt_i` high and `wb_dly_i` low sets `cause_o` at the next clock edge and disarms any running countdown, so that countdown never expires later.
- R6: An event with `wb_rpt_i` low, or any cycle with `wb_valid_i` low, leaves the countdown and `cause_o` unchanged. This holds whatever the value of `wb_dly_i`.
- R7: `stat_we_o` equals `wb_valid_i & wb_rpt_i` in the same cycle, whatever the value of `wb_dly_i` and whatever the timer state.
- R8: `cause_o` stays high until a cycle with `cause_clr_i` high. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq_o` is `cause_o & irq_en_i`. A cause recorded while the enable is low drives `irq_o` high as soon as the enable rises.
- R10: During reset and right after it, `cause_o` and `irq_o` are low and no countdown is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| wb_valid_i | input | 1 | Descriptor write-back event strobe |
| wb_rpt_i | input | 1 | Event requests status report |
| wb_dly_i | input | 1 | Event requests delayed interrupt |
| tick_i | input | 1 | Countdown granularity pulse |
| dly_val_i | input | 16 | Programmed countdown reload value |
| irq_en_i | input | 1 | Write-back interrupt enable |
| cause_clr_i | input | 1 | Write-one-to-clear strobe for the cause bit |
| stat_we_o | output | 1 | Descriptor status write-back strobe |
| cause_o | output | 1 | Sticky interrupt cause |
| irq_o | output | 1 | Interrupt request line |

## Verification
`stat_we_o` is combinational, so the bench checks it in the same cycle as the event. `irq_o` follows `irq_en_i` without delay. `cause_o` reacts one clock edge after an immediate event, after an expiring tick or after a clear. The bench therefore drives inputs just after a falling edge, checks all three outputs against a behavioural model a moment later, and advances the model on the rising edge. This keeps each comparison inside the cycle in which the result is due. Directed runs cover a zero delay, a tick in the load cycle, a reload, a cancel, and a set that collides with a clear. A random run follows them.

// File: rtl/tx_idt_pkg.sv
package tx_idt_pkg;

  // One write-back event as seen by the timer.
  typedef struct packed {
    logic vld;
    logic rpt;
    logic dly;
  } wb_ev_t;

  // Classified action for the countdown.
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_LOAD = 2'd1,
    EV_IMM  = 2'd2
  } ev_kind_t;

endpackage

// File: rtl/tx_idt_decode.sv
module tx_idt_decode
  import tx_idt_pkg::*;
(
  input  wb_ev_t   ev_i,
  output ev_kind_t kind_o,
  output logic     stat_we_o
);

  logic rpt_evt;

  assign rpt_evt   = ev_i.vld & ev_i.rpt;
  // The status write-back never waits for the timer.
  assign stat_we_o = rpt_evt;

  always_comb begin
    kind_o = EV_NONE;
    if (rpt_evt) begin
      kind_o = ev_i.dly ? EV_LOAD : EV_IMM;
    end
  end

endmodule

// File: rtl/tx_idt_counter.sv
module tx_idt_counter
  import tx_idt_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ev_kind_t         kind_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dly_val_i,
  output logic             fire_o
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en;
  logic             expire;

  assign expire = (kind_i == EV_NONE) && armed_q && tick_i && (cnt_q == '0);

  // Next-state logic
  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    cnt_en  = 1'b0;
    fire_o  = 1'b0;
    unique case (kind_i)
      EV_LOAD: begin
        cnt_d   = dly_val_i;
        armed_d = 1'b1;
        cnt_en  = 1'b1;
      end
      EV_IMM: begin
        armed_d = 1'b0;
        fire_o  = 1'b1;
      end
      default: begin
        if (expire) begin
          armed_d = 1'b0;
          fire_o  = 1'b1;
        end else if (armed_q && tick_i) begin
          cnt_d  = cnt_q - ONE;
          cnt_en = 1'b1;
        end
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R1 / R2: a delay-flagged event loads and arms
  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_LOAD) |=> (armed_q && cnt_q == $past(dly_val_i)));

  // R3: a running countdown steps down by one per tick
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_NONE && armed_q && tick_i && cnt_q != '0)
      |=> (armed_q && cnt_q == $past(cnt_q) - ONE));

  // R3: expiry disarms
  p_expire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_NONE && armed_q && tick_i && cnt_q == '0) |=> !armed_q);

  // R5: an undelayed report cancels the countdown
  p_cancel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_IMM) |=> !armed_q);

  // R6: no event and no tick leaves the countdown untouched
  p_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_NONE && !tick_i) |=> ($stable(cnt_q) && $stable(armed_q)));

  // R10: no firing from an idle, unarmed timer
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_NONE && !armed_q) |-> !fire_o);

endmodule

// File: rtl/tx_idt_cause.sv
module tx_idt_cause (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic cause_o,
  output logic irq_o
);

  logic cause_q, cause_d, cause_en;

  // Next-state logic: set has priority over clear.
  always_comb begin
    cause_en = fire_i | clr_i;
    cause_d  = fire_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= 1'b0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;
  assign irq_o   = cause_q & irq_en_i;

  // R4 / R8: any firing leaves the cause set, even with a clear present
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> cause_q);

  // R8: the cause only drops after a clear strobe
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cause_q) |-> $past(clr_i));

  // R9: the line never asserts without the enable
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && cause_q));

endmodule

// File: rtl/tx_irq_delay_timer.sv
module tx_irq_delay_timer
  import tx_idt_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wb_valid_i,
  input  logic             wb_rpt_i,
  input  logic             wb_dly_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dly_val_i,
  input  logic             irq_en_i,
  input  logic             cause_clr_i,
  output logic             stat_we_o,
  output logic             cause_o,
  output logic             irq_o
);

  localparam int SYNC_N = (RST_STAGES < 1) ? 1 : RST_STAGES;

  // Reset: asserted asynchronously, released through a flop chain.
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q[0] <= 1'b0;
    end else begin
      rst_sync_q[0] <= 1'b1;
    end
  end

  for (genvar s = 1; s < SYNC_N; s++) begin : g_rst_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rst_sync_q[s] <= 1'b0;
      end else begin
        rst_sync_q[s] <= rst_sync_q[s-1];
      end
    end
  end

  assign rst_n_int = rst_sync_q[SYNC_N-1];

  wb_ev_t   ev;
  ev_kind_t kind;
  logic     fire;

  assign ev.vld = wb_valid_i;
  assign ev.rpt = wb_rpt_i;
  assign ev.dly = wb_dly_i;

  tx_idt_decode u_decode (
    .ev_i      (ev),
    .kind_o    (kind),
    .stat_we_o (stat_we_o)
  );

  tx_idt_counter #(.DLY_W(DLY_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .kind_i    (kind),
    .tick_i    (tick_i),
    .dly_val_i (dly_val_i),
    .fire_o    (fire)
  );

  tx_idt_cause u_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .fire_i   (fire),
    .clr_i    (cause_clr_i),
    .irq_en_i (irq_en_i),
    .cause_o  (cause_o),
    .irq_o    (irq_o)
  );

  // R5: an undelayed report always fires
  p_imm_fire_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (wb_valid_i && wb_rpt_i && !wb_dly_i) |=> cause_o);

  // R9: a pending cause reaches the line when enabled
  p_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (cause_o && irq_en_i) |-> irq_o);

endmodule

// File: tb/tb_tx_irq_delay_timer.sv
module tb_tx_irq_delay_timer;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic wb_valid, wb_rpt, wb_dly, tick, irq_en, cause_clr;
  logic [DW-1:0] dly_val;
  logic stat_we, cause, irq;

  int n_tests = 0;
  int n_fail  = 0;

  // Reference model state
  bit     m_armed = 1'b0;
  int     m_cnt   = 0;
  bit     m_cause = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_irq_delay_timer #(.DLY_W(DW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wb_valid_i  (wb_valid),
    .wb_rpt_i    (wb_rpt),
    .wb_dly_i    (wb_dly),
    .tick_i      (tick),
    .dly_val_i   (dly_val),
    .irq_en_i    (irq_en),
    .cause_clr_i (cause_clr),
    .stat_we_o   (stat_we),
    .cause_o     (cause),
    .irq_o       (irq)
  );

  task automatic check(input bit act, input bit exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  // One clock cycle: drive, compare, advance model.
  task automatic cyc(input bit v, input bit r, input bit d, input bit t,
                     input bit c, input string tag);
    bit fire;
    wb_valid  = v;
    wb_rpt    = r;
    wb_dly    = d;
    tick      = t;
    cause_clr = c;
    #1;
    check(stat_we, v & r, {tag, " R7 stat_we"});
    check(cause, m_cause, {tag, " cause"});
    check(irq, m_cause & irq_en, {tag, " R9 irq"});
    @(posedge clk);
    fire = 1'b0;
    if (v && r && d) begin
      m_cnt   = int'(dly_val);
      m_armed = 1'b1;
    end else if (v && r) begin
      m_armed = 1'b0;
      fire    = 1'b1;
    end else if (m_armed && t) begin
      if (m_cnt == 0) begin
        m_armed = 1'b0;
        fire    = 1'b1;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
    if (fire) m_cause = 1'b1;
    else if (c) m_cause = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit t, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, t, 1'b0, tag);
  endtask

  task automatic clr_cause();
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 clear");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog R10: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wb_valid = 0; wb_rpt = 0; wb_dly = 0; tick = 0;
    irq_en = 1'b1; cause_clr = 0; dly_val = '0;
    repeat (3) @(negedge clk);
    #1;
    check(cause, 1'b0, "R10 reset cause");
    check(irq, 1'b0, "R10 reset irq");
    rst_n = 1'b1;
    idle(4, 1'b1, "R10 post-reset ticks");

    // R1/R3/R4: delay 3, expires on the 4th tick
    dly_val = 16'd3;
    cyc(1, 1, 1, 1, 0, "R1 load with tick");
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 1, 0, "R3 tick");
      cyc(0, 0, 0, 0, 0, "R3 gap");
    end
    check(cause, 1'b1, "R4 cause after expiry");
    idle(2, 1'b0, "R8 sticky");
    clr_cause();

    // R2: reload while counting
    dly_val = 16'd5;
    cyc(1, 1, 1, 0, 0, "R2 first load");
    idle(3, 1'b1, "R2 ticking");
    dly_val = 16'd2;
    cyc(1, 1, 1, 0, 0, "R2 reload");
    idle(2, 1'b1, "R2 after reload");
    check(cause, 1'b0, "R2 not yet expired");
    idle(2, 1'b1, "R2 expiry");
    clr_cause();

    // R3: zero delay fires on first tick
    dly_val = 16'd0;
    cyc(1, 1, 1, 0, 0, "R3 zero load");
    idle(2, 1'b0, "R3 zero wait");
    cyc(0, 0, 0, 1, 0, "R3 zero tick");
    check(cause, 1'b1, "R3 zero expiry");
    clr_cause();

    // R5: undelayed report fires and cancels
    dly_val = 16'd4;
    cyc(1, 1, 1, 0, 0, "R5 load");
    idle(2, 1'b1, "R5 ticking");
    cyc(1, 1, 0, 1, 0, "R5 immediate");
    check(cause, 1'b1, "R5 immediate cause");
    clr_cause();
    idle(10, 1'b1, "R5 cancelled");
    check(cause, 1'b0, "R5 no late expiry");

    // R6: delay flag without report, and strobe low, have no effect
    dly_val = 16'd2;
    cyc(1, 1, 1, 0, 0, "R6 load");
    cyc(0, 0, 0, 1, 0, "R6 tick");
    dly_val = 16'd9;
    cyc(1, 0, 1, 1, 0, "R6 dly no rpt");
    cyc(0, 1, 1, 0, 0, "R6 valid low");
    cyc(0, 1, 0, 0, 0, "R6 valid low imm");
    cyc(1, 0, 0, 1, 0, "R6 plain");
    check(cause, 1'b1, "R6 original countdown expired");
    clr_cause();

    // R9: enable off records cause, line follows enable later
    irq_en = 1'b0;
    cyc(1, 1, 0, 0, 0, "R9 imm while disabled");
    check(cause, 1'b1, "R9 cause recorded");
    check(irq, 1'b0, "R9 line low");
    irq_en = 1'b1;
    #1;
    check(irq, 1'b1, "R9 line after enable");
    clr_cause();

    // R8: set and clear in same cycle
    dly_val = 16'd0;
    cyc(1, 1, 1, 0, 0, "R8 load");
    cyc(0, 0, 0, 1, 1, "R8 expire with clear");
    check(cause, 1'b1, "R8 set wins");
    cyc(1, 1, 0, 0, 1, "R8 imm with clear");
    check(cause, 1'b1, "R8 set wins imm");
    clr_cause();

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) dly_val = DW'($urandom_range(0, 6));
      if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
      cyc($urandom_range(0, 5) == 0, $urandom_range(0, 1) == 1,
          $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 7) == 0, "R1-mix");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule